// File: doc/BRIEF.md
# SEC-DED Hamming Decoder, 8-bit Data

This block checks and repairs a 13-bit protected word. The word carries 8 data bits, 4 Hamming check bits and one overall parity bit. The decoder recomputes a 4-bit syndrome and the overall parity. It then sorts the word into one of three cases: clean, a single-bit error that it corrects, or a double-bit error that it only reports.

Check bits sit at the power-of-two positions 1, 2, 4 and 8. The overall parity bit sits at position 0. The syndrome is taken over the check bits as well, so a single flipped bit yields its own position number.

The interface is a single registered stage with no backpressure. A word presented with `valid_i` high produces the decoded data and flags, together with `valid_o`, one clock later.

Top module: `secded_dec`

## Requirements
- R1: Bit positions of `word_i` are numbered 0 to 12 from the LSB. Data bit 0 is at position 3, bits 1..3 are at positions 5, 6, 7, and bits 4..7 are at positions 9 to 12. Check bit k is at position 2^k, for k from 0 to 3. The overall parity bit is at position 0.
- R2: The parity is bad when the XOR of all 13 bits of `word_i` is 1, and good when it is 0.
- R3: Syndrome bit k is the XOR of every bit at positions 1..12 whose position number has bit k set. A word whose check bits were set by that rule gives syndrome 0.
- R4: Good parity with syndrome 0 gives `single_err_o`=0, `double_err_o`=0, and `data_o` equal to the data bits as received.
- R5: Bad parity with a syndrome of 1..12 inverts the bit at the syndrome position and sets `single_err_o`=1 and `double_err_o`=0. `data_o` is taken from the repaired word.
- R6: Bad parity with syndrome 0 means only the parity bit flipped. It gives `single_err_o`=1, `double_err_o`=0, and `data_o` unchanged.
- R7: Good parity with a nonzero syndrome gives `double_err_o`=1 and `single_err_o`=0. `data_o` is the data bits as received, uncorrected.
- R8: Bad parity with a syndrome of 13, 14 or 15 gives `double_err_o`=1 and `single_err_o`=0. `data_o` is the data bits as received.
- R9: `valid_o` equals `valid_i` delayed by one clock. The data and flag outputs for a word appear in that same cycle.
- R10: In a cycle with `valid_i` low, `data_o`, `single_err_o` and `double_err_o` keep their previous values.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A word is present on `word_i` |
| word_i | input | 13 | Protected word |
| valid_o | output | 1 | Decoded result is present |
| data_o | output | 8 | Corrected or passed-through data |
| single_err_o | output | 1 | Single error found and corrected |
| double_err_o | output | 1 | Uncorrectable error found |

## Verification
The hardest case to reach is bad parity with a syndrome of 13 to 15. No single or double flip can produce it. The stimulus flips three bits whose positions XOR to 13, 14 or 15, such as positions 1, 4 and 8. That leaves an odd flip count and an out-of-range syndrome.

Alongside this, every single flip and every pair of flips is applied to several encoded data values. Idle cycles are mixed in between words to exercise the hold behaviour.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int WORD_W = DATA_W + CHK_W + 1;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // position of the n-th data bit: n-th non-power-of-two position above 0
  function automatic int data_pos(input int n);
    int cnt;
    cnt = 0;
    for (int p = 1; p < WORD_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == n) return p;
        cnt++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/secded_syn.sv
module secded_syn
  import secded_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int CHK_W_P  = CHK_W
) (
  input  logic [WORD_W_P-1:0] word_i,
  output logic [CHK_W_P-1:0]  syn_o,
  output logic                par_err_o
);
  for (genvar k = 0; k < CHK_W_P; k++) begin : g_syn
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p < WORD_W_P; p++) begin
        if (((p >> k) & 1) == 1) acc = acc ^ word_i[p];
      end
      syn_o[k] = acc;
    end
  end

  assign par_err_o = ^word_i;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int CHK_W_P  = CHK_W,
  parameter int DATA_W_P = DATA_W
) (
  input  logic [WORD_W_P-1:0] word_i,
  input  logic [CHK_W_P-1:0]  syn_i,
  input  logic                par_err_i,
  output logic [DATA_W_P-1:0] data_o,
  output logic                single_o,
  output logic                double_o
);
  localparam int MAX_POS = WORD_W_P - 1;

  logic                syn_zero;
  logic                syn_in_range;
  logic                flip_en;
  logic [WORD_W_P-1:0] fixed;

  assign syn_zero     = (syn_i == '0);
  assign syn_in_range = (int'(syn_i) <= MAX_POS);
  assign flip_en      = par_err_i && syn_in_range;

  // position 0 flip leaves data untouched
  for (genvar p = 0; p < WORD_W_P; p++) begin : g_flip
    assign fixed[p] = word_i[p] ^ (flip_en && (int'(syn_i) == p));
  end

  for (genvar n = 0; n < DATA_W_P; n++) begin : g_extract
    localparam int POS = data_pos(n);
    assign data_o[n] = fixed[POS];
  end

  assign single_o = flip_en;
  assign double_o = (!par_err_i && !syn_zero) || (par_err_i && !syn_in_range);
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              single_err_o,
  output logic              double_err_o
);
  logic [CHK_W-1:0]  syn;
  logic              par_err;
  logic [DATA_W-1:0] data_d;
  logic              single_d;
  logic              double_d;

  secded_syn #(.WORD_W_P(WORD_W), .CHK_W_P(CHK_W)) u_syn (
    .word_i    (word_i),
    .syn_o     (syn),
    .par_err_o (par_err)
  );

  secded_fix #(.WORD_W_P(WORD_W), .CHK_W_P(CHK_W), .DATA_W_P(DATA_W)) u_fix (
    .word_i    (word_i),
    .syn_i     (syn),
    .par_err_i (par_err),
    .data_o    (data_d),
    .single_o  (single_d),
    .double_o  (double_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      data_o       <= '0;
      single_err_o <= 1'b0;
      double_err_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o       <= data_d;
        single_err_o <= single_d;
        double_err_o <= double_d;
      end
    end
  end
endmodule

// File: rtl/secded_dec_chk.sv
module secded_dec_chk
  import secded_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              single_err_o,
  input logic              double_err_o
);
  p_flags_mutex_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_err_o && double_err_o));

  p_valid_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(single_err_o) && $stable(double_err_o)));

  p_good_par_no_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(^word_i)) |=> !single_err_o);

  p_bad_par_flagged_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (^word_i)) |=> (single_err_o || double_err_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r11: assert (!valid_o && data_o == '0 && !single_err_o && !double_err_o);
    end
  end
endmodule

bind secded_dec secded_dec_chk u_chk (.*);

// File: tb/secded_dec_bench.sv
`timescale 1ns/1ps
module secded_dec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [12:0] word_i = '0;
  logic        valid_o;
  logic [7:0]  data_o;
  logic        single_err_o;
  logic        double_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic       e_valid = 0;
  logic [7:0] e_data  = 0;
  logic       e_single = 0;
  logic       e_double = 0;
  string      e_tag = "R11";

  int dpos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  always #5 clk_i = ~clk_i;

  secded_dec u_secded_dec (.*);

  function automatic logic [12:0] encode(input logic [7:0] d);
    logic [12:0] w;
    w = '0;
    foreach (dpos[n]) w[dpos[n]] = d[n];
    for (int k = 0; k < 4; k++) begin
      logic c;
      c = 0;
      for (int p = 1; p < 13; p++) if (p != (1 << k) && ((p >> k) & 1)) c ^= w[p];
      w[1 << k] = c;
    end
    w[0] = ^w[12:1];
    return w;
  endfunction

  task automatic model(input logic [12:0] w, output logic [7:0] d,
                       output logic s, output logic dd);
    int syn;
    logic par;
    logic [12:0] f;
    syn = 0;
    par = ^w;
    for (int p = 1; p < 13; p++) if (w[p]) syn ^= p;
    f = w; s = 0; dd = 0;
    if (par && syn <= 12) begin f[syn] = ~f[syn]; s = 1; end
    else if (par || syn != 0) dd = 1;
    foreach (dpos[n]) d[n] = f[dpos[n]];
  endtask

  task automatic compare();
    n_cmp++;
    if (valid_o !== e_valid || data_o !== e_data ||
        single_err_o !== e_single || double_err_o !== e_double) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%h s=%b dd=%b exp v=%b d=%h s=%b dd=%b", e_tag,
               valid_o, data_o, single_err_o, double_err_o,
               e_valid, e_data, e_single, e_double);
    end
  endtask

  task automatic step(input logic v, input logic [12:0] w, input string tag);
    @(negedge clk_i);
    compare();
    valid_i = v;
    word_i  = w;
    e_valid = v;
    e_tag   = tag;
    if (v) model(w, e_data, e_single, e_double);
  endtask

  initial begin
    logic [7:0] bases[5] = '{8'h00, 8'hff, 8'h67, 8'ha5, 8'h3c};
    repeat (2) @(negedge clk_i);
    compare();  // R11 reset state
    rst_ni = 1'b1;
    // R1 fixed examples: clean word and position-8 repair
    step(1, 13'b0110001101010, "R1");
    step(1, 13'b1011010110010, "R5");
    foreach (bases[b]) begin
      logic [12:0] cw;
      cw = encode(bases[b]);
      step(1, cw, "R4");
      step(0, 13'h1fff, "R10");
      for (int i = 0; i < 13; i++) step(1, cw ^ (13'd1 << i), i == 0 ? "R6" : "R5");
      for (int i = 0; i < 13; i++)
        for (int j = i + 1; j < 13; j++) begin
          step(1, cw ^ (13'd1 << i) ^ (13'd1 << j), "R7");
          if (((i + j) % 7) == 0) step(0, cw, "R10");
        end
      // R8 triple flips landing on syndrome 13..15
      step(1, cw ^ 13'b0000100010010, "R8");
      step(1, cw ^ 13'b0000100010100, "R8");
      step(1, cw ^ 13'b0000100010110 ^ 13'b0000000000001, "R8");
      step(1, cw ^ 13'b0000101000100, "R3");
      step(0, '0, "R9");
    end
    step(0, '0, "R9");
    step(0, '0, "R10");
    @(negedge clk_i);
    compare();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule